// File: doc/BRIEF.md
# Shift-First Restoring Integer Divider

This block divides one integer by another over several clock cycles. It returns the quotient on the low result word and the remainder on the high result word. A single double-width register holds the partial remainder in its upper half. As that register shifts left, it also collects quotient bits at its right end, so the block needs no separate quotient register.

The register is shifted once when an operation is accepted. After that, each clock cycle makes one trial subtraction of the divisor from the upper half. The difference is kept only when it is non-negative, and the register then shifts left with the new quotient bit entering at the least significant position. After the last iteration, the upper half is taken one bit to the right to give the true remainder. An extra bit sits above the upper half, so the borrow of a subtraction one bit wider than the operands decides each quotient bit. This keeps divisors with the top bit set correct.

A signed-mode input selects two's-complement operands. In that mode the core divides magnitudes and then fixes the signs of the results. A zero divisor skips the iterations and completes in a single cycle with a flag raised.

Top module: `divu_shift_first`

## Requirements
- R1: After reset, busy, done and the divide-by-zero flag are low, and both result words are zero.
- R2: With signed mode low and a non-zero divisor, the low result word is the unsigned quotient rounded down and the high word is the unsigned remainder, which is always below the divisor. For example, 7 divided by 2 gives 3 and 1.
- R3: With signed mode high, both operands are two's complement. The quotient is rounded toward zero and is negative when the operand signs differ. The remainder takes the sign of the dividend. For example, -7 / 2 gives -3 rem -1, and -7 / -2 gives 3 rem -1.
- R4: In signed mode, the most negative value divided by -1 yields the most negative value as the quotient (the bit pattern of the wrapped magnitude) and zero as the remainder.
- R5: A start seen at a rising edge while busy is low begins an operation. With a non-zero divisor, busy is high for exactly WIDTH cycles after that edge. Done is then high for one cycle, in the cycle after busy falls, and busy and done are never high together.
- R6: A start pulse while busy is high is ignored, and the running operation completes with its original operands and timing.
- R7: A zero divisor gives done and the divide-by-zero flag in the cycle right after the accepting edge, without busy. The low word is then all ones and the high word equals the dividend bit pattern.
- R8: The divide-by-zero flag is cleared by the next completion that has a non-zero divisor.
- R9: Unsigned divisors with the most significant bit set give correct results, because each quotient bit is decided by the borrow of a subtraction one bit wider than the operands.
- R10: The result words and the flag hold their values in every cycle between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a division when not busy |
| signed_i | input | 1 | Treat operands as two's complement |
| dividend_i | input | WIDTH | Dividend, sampled on the accepting edge |
| divisor_i | input | WIDTH | Divisor, sampled on the accepting edge |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle pulse when results are updated |
| div_zero_o | output | 1 | Last completed operation had a zero divisor |
| hi_o | output | WIDTH | Remainder |
| lo_o | output | WIDTH | Quotient |

## Verification
The bench runs a six-bit instance through every dividend and divisor pair in both modes. Expected quotients and remainders come from wide integer arithmetic in the bench. The sweep covers the most negative value divided by -1: a design that saturated or trapped there would return something other than the wrapped pattern. It also covers divisors with the top bit set: a design that took the quotient bit from the result's top bit alone would give wrong quotients there. Sign errors show up as a remainder with the divisor's sign, or as a quotient rounded toward minus infinity. A missing final right shift would return exactly twice the remainder. Directed cases check the following: busy and done timing, a start pulse inside a running operation (a design that restarted would return the second operands' results late), the one-cycle zero-divisor path, and results holding steady while the block is idle.

// File: rtl/divu_pkg.sv
package divu_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } divu_state_e;

endpackage

// File: rtl/divu_operand_prep.sv
module divu_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_i,
    input  logic             signed_i,
    output logic [WIDTH-1:0] mag_o,
    output logic             neg_o
);

    always_comb begin
        neg_o = signed_i & value_i[WIDTH-1];
        mag_o = neg_o ? (~value_i + 1'b1) : value_i;
    end

endmodule

// File: rtl/divu_trial_unit.sv
module divu_trial_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   upper_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] diff_o,
    output logic             fits_o
);

    logic [WIDTH:0] sub;

    // The upper value is always below twice the divisor, so the top bit
    // of this one-bit-wider difference is exactly the borrow.
    always_comb begin
        sub    = upper_i - {1'b0, divisor_i};
        fits_o = ~sub[WIDTH];
        diff_o = sub[WIDTH-1:0];
    end

endmodule

// File: rtl/divu_result_fix.sv
module divu_result_fix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] quo_mag_i,
    input  logic [WIDTH-1:0] rem_mag_i,
    input  logic             neg_q_i,
    input  logic             neg_r_i,
    output logic [WIDTH-1:0] quo_o,
    output logic [WIDTH-1:0] rem_o
);

    always_comb begin
        quo_o = neg_q_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
        rem_o = neg_r_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
    end

endmodule

// File: rtl/divu_shift_first.sv
module divu_shift_first
    import divu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             div_zero_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);

    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);
    localparam int RW = 2 * WIDTH;

    typedef struct packed {
        divu_state_e      state;
        logic [CW-1:0]    cnt;
        logic             ext;
        logic [RW-1:0]    rem;
        logic [WIDTH-1:0] dsr;
        logic             neg_q;
        logic             neg_r;
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
        logic             done;
        logic             dz;
    } divu_regs_t;

    divu_regs_t q, d;

    logic [WIDTH-1:0] mag_dvd, mag_dsr;
    logic             neg_dvd, neg_dsr;
    logic [WIDTH-1:0] diff;
    logic             fits;
    logic [WIDTH-1:0] upper_n;
    logic [RW:0]      shifted;
    logic [WIDTH-1:0] quo_fix, rem_fix;

    divu_operand_prep #(.WIDTH(WIDTH)) u_prep_dvd (
        .value_i  (dividend_i),
        .signed_i (signed_i),
        .mag_o    (mag_dvd),
        .neg_o    (neg_dvd)
    );

    divu_operand_prep #(.WIDTH(WIDTH)) u_prep_dsr (
        .value_i  (divisor_i),
        .signed_i (signed_i),
        .mag_o    (mag_dsr),
        .neg_o    (neg_dsr)
    );

    divu_trial_unit #(.WIDTH(WIDTH)) u_trial (
        .upper_i   ({q.ext, q.rem[RW-1:WIDTH]}),
        .divisor_i (q.dsr),
        .diff_o    (diff),
        .fits_o    (fits)
    );

    // Keep the difference or fall back to the pre-subtract value, then
    // shift the whole register left with the quotient bit at the bottom.
    always_comb begin
        upper_n = fits ? diff : q.rem[RW-1:WIDTH];
        shifted = {upper_n, q.rem[WIDTH-1:0], fits};
    end

    // Final step: upper half moved right by one gives the remainder.
    divu_result_fix #(.WIDTH(WIDTH)) u_fix (
        .quo_mag_i (shifted[WIDTH-1:0]),
        .rem_mag_i (shifted[RW:WIDTH+1]),
        .neg_q_i   (q.neg_q),
        .neg_r_i   (q.neg_r),
        .quo_o     (quo_fix),
        .rem_o     (rem_fix)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (divisor_i == '0) begin
                        d.done = 1'b1;
                        d.dz   = 1'b1;
                        d.hi   = dividend_i;
                        d.lo   = '1;
                    end else begin
                        d.state = ST_RUN;
                        d.cnt   = '0;
                        d.ext   = 1'b0;
                        d.rem   = {{(WIDTH-1){1'b0}}, mag_dvd, 1'b0};
                        d.dsr   = mag_dsr;
                        d.neg_q = neg_dvd ^ neg_dsr;
                        d.neg_r = neg_dvd;
                    end
                end
            end
            ST_RUN: begin
                {d.ext, d.rem} = shifted;
                d.cnt          = q.cnt + 1'b1;
                if (q.cnt == LAST) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    d.dz    = 1'b0;
                    d.hi    = rem_fix;
                    d.lo    = quo_fix;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy_o     = (q.state == ST_RUN);
        done_o     = q.done;
        div_zero_o = q.dz;
        hi_o       = q.hi;
        lo_o       = q.lo;
    end

endmodule

// File: rtl/divu_shift_first_chk.sv
module divu_shift_first_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic             signed_i,
    input logic [WIDTH-1:0] divisor_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             div_zero_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o
);

    int unsigned      run_cnt;
    logic [WIDTH-1:0] dsr_cap;
    logic             sgn_cap;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_cnt <= 0;
            dsr_cap <= '0;
            sgn_cap <= 1'b0;
        end else begin
            run_cnt <= busy_o ? run_cnt + 1 : 0;
            if (start_i && !busy_o) begin
                dsr_cap <= divisor_i;
                sgn_cap <= signed_i;
            end
        end
    end

    AST_NO_BUSY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_o && done_o)); // R5

    AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !div_zero_o) |-> (run_cnt == WIDTH)); // R5

    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> (busy_o || done_o)); // R6

    AST_DZ_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && divisor_i == '0) |=> (done_o && div_zero_o && !busy_o)); // R7

    AST_DZ_QUOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && div_zero_o) |-> (&lo_o)); // R7

    AST_UNS_REM_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !div_zero_o && !sgn_cap) |-> (hi_o < dsr_cap)); // R2

    AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(hi_o) && $stable(lo_o) && $stable(div_zero_o))); // R10

endmodule

bind divu_shift_first divu_shift_first_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .signed_i   (signed_i),
    .divisor_i  (divisor_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .div_zero_o (div_zero_o),
    .hi_o       (hi_o),
    .lo_o       (lo_o)
);

// File: tb/divu_shift_first_tb_top.sv
`timescale 1ns/1ps
module divu_shift_first_tb_top;

    localparam int W = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sgn = 1'b0;
    logic [W-1:0] dvd = '0;
    logic [W-1:0] dsr = '0;
    logic         busy, done, dz;
    logic [W-1:0] hi, lo;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    divu_shift_first #(.WIDTH(W)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .signed_i   (sgn),
        .dividend_i (dvd),
        .divisor_i  (dsr),
        .busy_o     (busy),
        .done_o     (done),
        .div_zero_o (dz),
        .hi_o       (hi),
        .lo_o       (lo)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input bit s, output logic [W-1:0] eq,
                                  output logic [W-1:0] er);
        longint sa, sb, qq, rr;
        if (b == '0) begin
            eq = '1;
            er = a;
        end else if (s) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            qq = sa / sb;
            rr = sa % sb;
            eq = qq[W-1:0];
            er = rr[W-1:0];
        end else begin
            eq = a / b;
            er = a % b;
        end
    endfunction

    function automatic string req_of(input logic [W-1:0] a, input logic [W-1:0] b,
                                     input bit s);
        if (b == '0) return "R7";
        if (s && a == {1'b1, {(W-1){1'b0}}} && b == '1) return "R4";
        if (s) return "R3";
        if (b[W-1]) return "R9";
        return "R2";
    endfunction

    // Start at a falling edge, wait for done, compare with the model.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                          input bit poke);
        logic [W-1:0] eq, er;
        string        rq;
        int           n;
        model(a, b, s, eq, er);
        rq = req_of(a, b, s);
        @(negedge clk);
        start = 1'b1; dvd = a; dsr = b; sgn = s;
        @(negedge clk);
        start = 1'b0;
        if (b != '0) begin
            chk(busy == 1'b1 && done == 1'b0, "R5", "busy after accept", busy, 1);
        end else begin
            chk(busy == 1'b0 && done == 1'b1, "R7", "zero divisor one cycle", done, 1);
        end
        if (poke && b != '0) begin
            // R6: second start with other operands during the run
            start = 1'b1; dvd = ~a; dsr = 1; sgn = ~s;
            @(negedge clk);
            start = 1'b0; dvd = '0; dsr = '0;
            n = 1;
        end else begin
            n = 0;
        end
        while (!done && n < 4 * W + 8) begin
            @(negedge clk);
            n++;
        end
        chk(n == ((b == '0) ? 0 : W), (b == '0) ? "R7" : (poke ? "R6" : "R5"),
            "cycles to done", n, (b == '0) ? 0 : W);
        chk(lo == eq, poke ? "R6" : rq, "quotient", lo, eq);
        chk(hi == er, poke ? "R6" : rq, "remainder", hi, er);
        chk(dz == (b == '0), (b == '0) ? "R7" : "R8", "div-zero flag", dz, b == '0);
        @(negedge clk);
        chk(done == 1'b0, "R5", "done is a single pulse", done, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R5 watchdog expired: actual %0d expected %0d", cyc, 190000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] hold_hi, hold_lo;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(dz == 1'b0, "R1", "flag in reset", dz, 0);
        chk(hi == '0 && lo == '0, "R1", "results in reset", {hi, lo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", busy, 0);

        // Directed cases: R2 and R3 worked examples
        run_op(W'(7), W'(2), 1'b0, 1'b0);
        run_op(W'(-7), W'(2), 1'b1, 1'b0);
        run_op(W'(-7), W'(-2), 1'b1, 1'b0);
        // R4 most negative by minus one
        run_op({1'b1, {(W-1){1'b0}}}, '1, 1'b1, 1'b0);
        // R9 large unsigned divisor
        run_op('1, {1'b1, {(W-1){1'b0}}}, 1'b0, 1'b0);
        // R7 then R8
        run_op(W'(13), '0, 1'b0, 1'b0);
        run_op(W'(13), W'(5), 1'b0, 1'b0);
        // R6 start during a run
        run_op(W'(50), W'(7), 1'b0, 1'b1);

        // R10 hold while idle and while idle inputs wiggle
        hold_hi = hi;
        hold_lo = lo;
        dvd = W'(21); dsr = W'(4); sgn = 1'b1;
        repeat (5) @(negedge clk);
        chk(hi == hold_hi, "R10", "remainder held", hi, hold_hi);
        chk(lo == hold_lo, "R10", "quotient held", lo, hold_lo);

        // Exhaustive sweep in both modes
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    run_op(W'(a), W'(b), s[0], 1'b0);
                end
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule